// File: doc/BRIEF.md
# CMOS Real-Time Clock with Index/Data Port

This block is a PC-style real-time clock that is reached through two byte-wide ports. A write to the index port chooses one of 128 register slots. The data port then reads or writes the byte in that slot. Behind the ports are two resources:

- a 128-byte non-volatile style RAM;
- a time-of-day and calendar counter that runs from a 32.768 kHz tick enable.

Eight fixed slots and the status slot are read from the live clock and not from the RAM. The clock fields are returned in packed BCD. The status slot reports the selected time base. It also carries an update-in-progress flag that is raised during the last few ticks before each second boundary.

When reset is released, the RAM is zero. Two build-time parameters, the memory size below the 32-bit gap and the memory size above 4 GB, are converted into 64 KB units and preloaded into fixed slots. The clock is set through a separate load port: one strobe copies all BCD fields and restarts the sub-second count. Data-port writes never reach the running clock.

The calendar carries from seconds up to century through a small state machine, one field per clock cycle. The states are:

| State | What it does | Transitions |
|---|---|---|
| `CAL_IDLE` | Waits for a second pulse, then steps the seconds. | On a seconds wrap, goes to `CAL_MIN`. |
| `CAL_MIN` | Steps the minutes. | On a wrap, goes to `CAL_HOUR`; otherwise back to `CAL_IDLE`. |
| `CAL_HOUR` | Steps the hours. | On a wrap, goes to `CAL_DAY`; otherwise back to `CAL_IDLE`. |
| `CAL_DAY` | Steps the weekday and the day of month. | At month end, goes to `CAL_MON`; otherwise back to `CAL_IDLE`. |
| `CAL_MON` | Steps the month. | After December, goes to `CAL_YEAR`; otherwise back to `CAL_IDLE`. |
| `CAL_YEAR` | Steps the year. | After 99, goes to `CAL_CENT`; otherwise back to `CAL_IDLE`. |
| `CAL_CENT` | Steps the century. | Returns to `CAL_IDLE`. |

A load strobe moves the machine from any state to `CAL_IDLE`.

Top module: `cmos_rtc_port`

## Requirements
- R1: A single-byte write to offset 0 stores the low 7 bits of the byte as the index. A single-byte read of offset 0 returns the stored index with bit 7 clear. The index is 0 after reset.
- R2: A single-byte write to offset 1 stores the byte in RAM at the current index. A single-byte read of offset 1 at any index other than the clock and status indices returns that RAM byte.
- R3: An access whose byte count (`acc_len`) is not 1 is ignored. A write changes neither the index nor the RAM. A read returns 0x00 on `rd_data`.
- R4: Data-port reads return live BCD clock fields at these indices: 0x00 seconds, 0x02 minutes, 0x04 hours (00–23), 0x06 weekday (1 = Sunday to 7), 0x07 day of month, 0x08 month (1–12), 0x09 year within the century, and 0x32 century. The values after reset are 00:00:00, weekday 1, day 01, month 01, year 00, century 20.
- R5: A data-port read at index 0x0A returns 0x20 with bit 7 replaced by the update-in-progress flag. The result is 0xA0 when the flag is set and 0x20 when it is clear.
- R6: The update-in-progress flag is set while the sub-second count is within the last `UIP_TICKS` counts of its 2^`PRESC_W` period. The defaults are counts 32760–32767. The flag is clear at every other count.
- R7: The sub-second count advances only on cycles with `tick` high. The seconds field steps once each time the count wraps, which is after 2^`PRESC_W` ticks. With `tick` low, the time does not change.
- R8: Seconds and minutes go from 59 to 00, and hours go from 23 to 00, each carrying into the next field. The BCD ones digit carries into the tens digit after 9. The weekday steps with every day and goes from 7 to 1.
- R9: The day of month goes back to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days in a leap year and 28 otherwise. A year is a leap year when it is a nonzero year divisible by 4, or year 00 of a century divisible by 4.
- R10: Month 12 goes to 01 and increments the year. Year 99 goes to 00 and increments the century.
- R11: A `ld_stb` cycle copies all eight load inputs into the clock and restarts the sub-second count at 0. The load wins over a second step in the same cycle.
- R12: Data-port writes to clock indices change only the RAM and leave the running clock unchanged.
- R13: At reset, min(0xFFFF, max(0, `MEM_LOW_BYTES` − 16 MB) / 64 KB) is placed little-endian at indices 0x34–0x35. min(0xFFFFFF, `MEM_HIGH_BYTES` / 64 KB) is placed little-endian at indices 0x5B–0x5D. All other RAM bytes reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 32.768 kHz tick enable, high for one clock per tick |
| acc_valid | input | 1 | Port access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = index port, 1 = data port |
| acc_len | input | 4 | Access size in bytes; only 1 is accepted |
| acc_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, registered, updated on each read request |
| ld_stb | input | 1 | Load all clock fields |
| ld_sec | input | 8 | BCD seconds to load |
| ld_min | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hours to load |
| ld_wday | input | 8 | BCD weekday to load |
| ld_mday | input | 8 | BCD day of month to load |
| ld_mon | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD year within the century to load |
| ld_cent | input | 8 | BCD century to load |

## Verification
The hardest situation to reach is the status read that falls exactly inside the update window. At full rate the window is only 8 ticks out of 32768, and it moves with every tick. The bench builds the clock with a 6-bit prescaler, so the window covers counts 56–63. It holds `tick` low, loads a time to zero the count, and then pulses an exact number of ticks before each status read. This places the read one count before, at, inside and just past the window.

The deep carries, such as a century turnover or February in years 1900, 2000 and 2024, are reached by loading the instant just before the boundary and running one full second.

// File: rtl/cmos_rtc_pkg.sv
package cmos_rtc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] mins;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
        logic [7:0] cent;
    } rtc_time_t;

    typedef enum logic [2:0] {
        CAL_IDLE,
        CAL_MIN,
        CAL_HOUR,
        CAL_DAY,
        CAL_MON,
        CAL_YEAR,
        CAL_CENT
    } cal_state_e;

    // Slots where the software-visible clock fields live (decoded by readers)
    localparam logic [6:0] IX_SEC    = 7'h00;
    localparam logic [6:0] IX_MIN    = 7'h02;
    localparam logic [6:0] IX_HOUR   = 7'h04;
    localparam logic [6:0] IX_WDAY   = 7'h06;
    localparam logic [6:0] IX_MDAY   = 7'h07;
    localparam logic [6:0] IX_MON    = 7'h08;
    localparam logic [6:0] IX_YEAR   = 7'h09;
    localparam logic [6:0] IX_STATUS = 7'h0A;
    localparam logic [6:0] IX_CENT   = 7'h32;

    // Memory-size preload slots
    localparam logic [6:0] IX_EXT_LO  = 7'h34;
    localparam logic [6:0] IX_EXT_HI  = 7'h35;
    localparam logic [6:0] IX_HIGH_B0 = 7'h5B;
    localparam logic [6:0] IX_HIGH_B1 = 7'h5C;
    localparam logic [6:0] IX_HIGH_B2 = 7'h5D;

    localparam rtc_time_t RTC_RESET_TIME = '{
        sec: 8'h00, mins: 8'h00, hour: 8'h00, wday: 8'h01,
        mday: 8'h01, mon: 8'h01, year: 8'h00, cent: 8'h20
    };

    // Packed-BCD increment without range wrap
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    // Gregorian leap test on BCD year-in-century and century
    function automatic logic bcd_is_leap(input logic [7:0] yy, input logic [7:0] cc);
        logic [4:0] ysum;
        logic [4:0] csum;
        // value mod 4 == (2*tens + ones) mod 4
        ysum = {yy[7:4], 1'b0} + {1'b0, yy[3:0]};
        csum = {cc[7:4], 1'b0} + {1'b0, cc[3:0]};
        if (yy != 8'h00) begin
            return (ysum[1:0] == 2'd0);
        end
        return (csum[1:0] == 2'd0);
    endfunction

    function automatic logic [7:0] bcd_month_days(input logic [7:0] mon,
                                                  input logic [7:0] yy,
                                                  input logic [7:0] cc);
        logic [7:0] d;
        unique case (mon)
            8'h02:                      d = bcd_is_leap(yy, cc) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_W   = 15,
    parameter int UIP_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clear_i,
    output logic wrap_o,
    output logic uip_o
);
    localparam logic [PRESC_W-1:0] CNT_MAX   = {PRESC_W{1'b1}};
    localparam logic [PRESC_W-1:0] UIP_START = CNT_MAX - PRESC_W'(UIP_TICKS - 1);

    logic [PRESC_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wrap_o = tick_i && !clear_i && (cnt_q == CNT_MAX);
    assign uip_o  = (cnt_q >= UIP_START);

    // R6
    uip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip_o) |-> (cnt_q == '0));

    // R7
    wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0) && !uip_o);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import cmos_rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_pulse_i,
    input  logic      load_i,
    input  rtc_time_t load_time_i,
    output rtc_time_t time_o
);
    cal_state_e st_q, st_d;
    rtc_time_t  tm_q, tm_d;
    logic [7:0] month_len;

    assign month_len = bcd_month_days(tm_q.mon, tm_q.year, tm_q.cent);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CAL_IDLE;
            tm_q <= RTC_RESET_TIME;
        end else begin
            st_q <= st_d;
            tm_q <= tm_d;
        end
    end

    // Next state and field updates
    always_comb begin
        st_d = st_q;
        tm_d = tm_q;
        if (load_i) begin
            tm_d = load_time_i;
            st_d = CAL_IDLE;
        end else begin
            unique case (st_q)
                CAL_IDLE: begin
                    if (sec_pulse_i) begin
                        if (tm_q.sec >= 8'h59) begin
                            tm_d.sec = 8'h00;
                            st_d     = CAL_MIN;
                        end else begin
                            tm_d.sec = bcd_inc(tm_q.sec);
                        end
                    end
                end
                CAL_MIN: begin
                    if (tm_q.mins >= 8'h59) begin
                        tm_d.mins = 8'h00;
                        st_d      = CAL_HOUR;
                    end else begin
                        tm_d.mins = bcd_inc(tm_q.mins);
                        st_d      = CAL_IDLE;
                    end
                end
                CAL_HOUR: begin
                    if (tm_q.hour >= 8'h23) begin
                        tm_d.hour = 8'h00;
                        st_d      = CAL_DAY;
                    end else begin
                        tm_d.hour = bcd_inc(tm_q.hour);
                        st_d      = CAL_IDLE;
                    end
                end
                CAL_DAY: begin
                    tm_d.wday = (tm_q.wday >= 8'h07) ? 8'h01 : bcd_inc(tm_q.wday);
                    if (tm_q.mday >= month_len) begin
                        tm_d.mday = 8'h01;
                        st_d      = CAL_MON;
                    end else begin
                        tm_d.mday = bcd_inc(tm_q.mday);
                        st_d      = CAL_IDLE;
                    end
                end
                CAL_MON: begin
                    if (tm_q.mon >= 8'h12) begin
                        tm_d.mon = 8'h01;
                        st_d     = CAL_YEAR;
                    end else begin
                        tm_d.mon = bcd_inc(tm_q.mon);
                        st_d     = CAL_IDLE;
                    end
                end
                CAL_YEAR: begin
                    if (tm_q.year >= 8'h99) begin
                        tm_d.year = 8'h00;
                        st_d      = CAL_CENT;
                    end else begin
                        tm_d.year = bcd_inc(tm_q.year);
                        st_d      = CAL_IDLE;
                    end
                end
                CAL_CENT: begin
                    tm_d.cent = (tm_q.cent >= 8'h99) ? 8'h00 : bcd_inc(tm_q.cent);
                    st_d      = CAL_IDLE;
                end
                default: st_d = CAL_IDLE;
            endcase
        end
    end

    assign time_o = tm_q;

    // R11
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (time_o == $past(load_time_i)) && (st_q == CAL_IDLE));

    // R7
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse_i && !load_i && st_q == CAL_IDLE) |=> (time_o.sec != $past(time_o.sec)));

    // R7
    no_pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_pulse_i && !load_i && st_q == CAL_IDLE) |=> $stable(time_o));

    // R8
    carry_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CAL_MIN && !load_i) |=> $stable(time_o.sec) && (time_o.mins != $past(time_o.mins)));

endmodule

// File: rtl/rtc_nvram.sv
module rtc_nvram
    import cmos_rtc_pkg::*;
#(
    parameter int          AW        = 7,
    parameter logic [15:0] EXT_UNITS = 16'h0000,
    parameter logic [23:0] HIGH_UNITS = 24'h000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    function automatic logic [7:0] preload_byte(input int unsigned a);
        logic [7:0] b;
        b = 8'h00;
        if (a == 32'(IX_EXT_LO))  b = EXT_UNITS[7:0];
        if (a == 32'(IX_EXT_HI))  b = EXT_UNITS[15:8];
        if (a == 32'(IX_HIGH_B0)) b = HIGH_UNITS[7:0];
        if (a == 32'(IX_HIGH_B1)) b = HIGH_UNITS[15:8];
        if (a == 32'(IX_HIGH_B2)) b = HIGH_UNITS[23:16];
        return b;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= preload_byte(i);
            end
        end else if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[addr_i];

    // R2
    ram_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem[$past(addr_i)] == $past(wdata_i)));

    // R3
    ram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> (mem[$past(addr_i)] == $past(rdata_o)));

endmodule

// File: rtl/cmos_rtc_port.sv
module cmos_rtc_port
    import cmos_rtc_pkg::*;
#(
    parameter logic [63:0] MEM_LOW_BYTES  = 64'h0000_0000_8000_0000,
    parameter logic [63:0] MEM_HIGH_BYTES = 64'h0000_0000_0000_0000,
    parameter int          PRESC_W        = 15,
    parameter int          UIP_TICKS      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_addr,
    input  logic [3:0] acc_len,
    input  logic [7:0] acc_wdata,
    output logic [7:0] rd_data,
    input  logic       ld_stb,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_mday,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    input  logic [7:0] ld_cent
);
    localparam int          IDX_W      = 7;
    localparam logic [63:0] LOW_FLOOR  = 64'h0000_0000_0100_0000;
    localparam logic [63:0] LOW_EXCESS = (MEM_LOW_BYTES > LOW_FLOOR) ? (MEM_LOW_BYTES - LOW_FLOOR) : 64'd0;
    localparam logic [63:0] LOW_UNITS  = LOW_EXCESS >> 16;
    localparam logic [63:0] HIGH_UNITS_FULL = MEM_HIGH_BYTES >> 16;
    localparam logic [15:0] EXT_UNITS  = (LOW_UNITS > 64'h0000_FFFF) ? 16'hFFFF : LOW_UNITS[15:0];
    localparam logic [23:0] HIGH_UNITS = (HIGH_UNITS_FULL > 64'h00FF_FFFF) ? 24'hFF_FFFF : HIGH_UNITS_FULL[23:0];

    logic [IDX_W-1:0] idx_q;
    logic             acc_ok;
    logic             ram_we;
    logic [7:0]       ram_rd;
    logic [7:0]       data_byte;
    logic             sec_pulse;
    logic             uip;
    rtc_time_t        load_time;
    rtc_time_t        now;

    assign acc_ok = acc_valid && (acc_len == 4'd1);
    assign ram_we = acc_ok && acc_write && acc_addr;

    assign load_time = '{sec: ld_sec, mins: ld_min, hour: ld_hour, wday: ld_wday,
                         mday: ld_mday, mon: ld_mon, year: ld_year, cent: ld_cent};

    rtc_prescaler #(
        .PRESC_W   (PRESC_W),
        .UIP_TICKS (UIP_TICKS)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .clear_i (ld_stb),
        .wrap_o  (sec_pulse),
        .uip_o   (uip)
    );

    rtc_calendar u_cal (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_pulse_i (sec_pulse),
        .load_i      (ld_stb),
        .load_time_i (load_time),
        .time_o      (now)
    );

    rtc_nvram #(
        .AW         (IDX_W),
        .EXT_UNITS  (EXT_UNITS),
        .HIGH_UNITS (HIGH_UNITS)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ram_we),
        .addr_i  (idx_q),
        .wdata_i (acc_wdata),
        .rdata_o (ram_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (acc_ok && acc_write && !acc_addr) begin
            idx_q <= acc_wdata[IDX_W-1:0];
        end
    end

    always_comb begin
        unique case (idx_q)
            IX_SEC:    data_byte = now.sec;
            IX_MIN:    data_byte = now.mins;
            IX_HOUR:   data_byte = now.hour;
            IX_WDAY:   data_byte = now.wday;
            IX_MDAY:   data_byte = now.mday;
            IX_MON:    data_byte = now.mon;
            IX_YEAR:   data_byte = now.year;
            IX_CENT:   data_byte = now.cent;
            IX_STATUS: data_byte = {uip, 2'b01, 5'b00000};
            default:   data_byte = ram_rd;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
        end else if (acc_valid && !acc_write) begin
            if (!acc_ok) begin
                rd_data <= 8'h00;
            end else if (!acc_addr) begin
                rd_data <= {1'b0, idx_q};
            end else begin
                rd_data <= data_byte;
            end
        end
    end

    // R1
    idx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && acc_write && !acc_addr) |=> (idx_q == $past(acc_wdata[6:0])));

    // R3
    wide_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ok) |=> $stable(idx_q));

    // R3
    wide_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ok && !acc_write) |=> (rd_data == 8'h00));

    // R5
    status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && !acc_write && acc_addr && idx_q == IX_STATUS) |=> (rd_data[6:0] == 7'h20));

    // R12
    data_write_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !ld_stb && !sec_pulse && !tick) |=> $stable(now));

endmodule

// File: tb/cmos_rtc_port_bench.sv
`timescale 1ns/1ps
module cmos_rtc_port_bench;
    import cmos_rtc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic       acc_addr = 1'b0;
    logic [3:0] acc_len = 4'd1;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] rd_data_s;
    logic       ld_stb = 1'b0;
    rtc_time_t  ld_t = RTC_RESET_TIME;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    cmos_rtc_port #(
        .MEM_LOW_BYTES  (64'h0000_0000_8003_0000),
        .MEM_HIGH_BYTES (64'h0000_0001_2345_0000),
        .PRESC_W        (6),
        .UIP_TICKS      (8)
    ) u_cmos_rtc_port (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_len(acc_len), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .ld_stb(ld_stb), .ld_sec(ld_t.sec), .ld_min(ld_t.mins), .ld_hour(ld_t.hour),
        .ld_wday(ld_t.wday), .ld_mday(ld_t.mday), .ld_mon(ld_t.mon),
        .ld_year(ld_t.year), .ld_cent(ld_t.cent)
    );

    cmos_rtc_port #(
        .MEM_LOW_BYTES  (64'h0000_0010_0000_0000),
        .MEM_HIGH_BYTES (64'h0000_0100_0000_0000),
        .PRESC_W        (6),
        .UIP_TICKS      (8)
    ) u_cmos_rtc_port_sat (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_len(acc_len), .acc_wdata(acc_wdata), .rd_data(rd_data_s),
        .ld_stb(ld_stb), .ld_sec(ld_t.sec), .ld_min(ld_t.mins), .ld_hour(ld_t.hour),
        .ld_wday(ld_t.wday), .ld_mday(ld_t.mday), .ld_mon(ld_t.mon),
        .ld_year(ld_t.year), .ld_cent(ld_t.cent)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic ad, input logic [3:0] len,
                       input logic [7:0] wd, output logic [7:0] rd, output logic [7:0] rds);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = ad;
        acc_len   = len;
        acc_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        acc_len   = 4'd1;
        rd  = rd_data;
        rds = rd_data_s;
    endtask

    task automatic set_idx(input logic [7:0] i);
        logic [7:0] a, b;
        bus(1'b1, 1'b0, 4'd1, i, a, b);
    endtask

    task automatic rd_slot(input logic [7:0] i, output logic [7:0] v, output logic [7:0] vs);
        set_idx(i);
        bus(1'b0, 1'b1, 4'd1, 8'h00, v, vs);
    endtask

    task automatic wr_slot(input logic [7:0] i, input logic [7:0] v);
        logic [7:0] a, b;
        set_idx(i);
        bus(1'b1, 1'b1, 4'd1, v, a, b);
    endtask

    task automatic do_load(input rtc_time_t t);
        ld_t   = t;
        ld_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld_stb = 1'b0;
    endtask

    task automatic pulse_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic cmp_time(input string req, input rtc_time_t exp);
        logic [7:0] v, vs;
        rd_slot(8'h00, v, vs); chk({req, " sec"},  v, exp.sec);
        rd_slot(8'h02, v, vs); chk({req, " min"},  v, exp.mins);
        rd_slot(8'h04, v, vs); chk({req, " hour"}, v, exp.hour);
        rd_slot(8'h06, v, vs); chk({req, " wday"}, v, exp.wday);
        rd_slot(8'h07, v, vs); chk({req, " mday"}, v, exp.mday);
        rd_slot(8'h08, v, vs); chk({req, " mon"},  v, exp.mon);
        rd_slot(8'h09, v, vs); chk({req, " year"}, v, exp.year);
        rd_slot(8'h32, v, vs); chk({req, " cent"}, v, exp.cent);
    endtask

    // One full second from a loaded instant, then freeze and compare
    task automatic t_roll(input string req, input rtc_time_t start, input rtc_time_t exp);
        tick = 1'b0;
        do_load(start);
        pulse_ticks(80);
        cmp_time(req, exp);
    endtask

    task automatic t_reset;
        logic [7:0] v, vs;
        bus(1'b0, 1'b0, 4'd1, 8'h00, v, vs);
        chk("R1 reset index", v, 8'h00);
        cmp_time("R4 reset time", RTC_RESET_TIME);
        rd_slot(8'h0A, v, vs);
        chk("R5 reset status", v, 8'h20);
    endtask

    task automatic t_index;
        logic [7:0] v, vs;
        set_idx(8'hC5);
        bus(1'b0, 1'b0, 4'd1, 8'h00, v, vs);
        chk("R1 index low7", v, 8'h45);
        set_idx(8'h7F);
        bus(1'b0, 1'b0, 4'd1, 8'h00, v, vs);
        chk("R1 index 7F", v, 8'h7F);
    endtask

    task automatic t_ram;
        logic [7:0] v, vs;
        wr_slot(8'h10, 8'hA5);
        wr_slot(8'h7F, 8'h3C);
        rd_slot(8'h10, v, vs); chk("R2 ram 10", v, 8'hA5);
        rd_slot(8'h7F, v, vs); chk("R2 ram 7F", v, 8'h3C);
        rd_slot(8'h01, v, vs); chk("R2 ram untouched 01", v, 8'h00);
    endtask

    task automatic t_wide;
        logic [7:0] v, vs;
        set_idx(8'h10);
        bus(1'b1, 1'b0, 4'd2, 8'h22, v, vs);
        bus(1'b0, 1'b0, 4'd1, 8'h00, v, vs);
        chk("R3 wide index write", v, 8'h10);
        bus(1'b1, 1'b1, 4'd4, 8'h99, v, vs);
        bus(1'b1, 1'b1, 4'd0, 8'h98, v, vs);
        bus(1'b0, 1'b1, 4'd1, 8'h00, v, vs);
        chk("R3 wide data write", v, 8'hA5);
        bus(1'b0, 1'b1, 4'd2, 8'h00, v, vs);
        chk("R3 wide read", v, 8'h00);
    endtask

    task automatic t_preload;
        logic [7:0] v, vs;
        rd_slot(8'h34, v, vs); chk("R13 ext lo", v, 8'h03); chk("R13 ext lo sat", vs, 8'hFF);
        rd_slot(8'h35, v, vs); chk("R13 ext hi", v, 8'h7F); chk("R13 ext hi sat", vs, 8'hFF);
        rd_slot(8'h5B, v, vs); chk("R13 high b0", v, 8'h45); chk("R13 high b0 sat", vs, 8'hFF);
        rd_slot(8'h5C, v, vs); chk("R13 high b1", v, 8'h23); chk("R13 high b1 sat", vs, 8'hFF);
        rd_slot(8'h5D, v, vs); chk("R13 high b2", v, 8'h01); chk("R13 high b2 sat", vs, 8'hFF);
        rd_slot(8'h33, v, vs); chk("R13 other zero", v, 8'h00);
    endtask

    task automatic t_uip;
        logic [7:0] v, vs;
        rtc_time_t t;
        t = '{sec: 8'h30, mins: 8'h10, hour: 8'h08, wday: 8'h03,
              mday: 8'h15, mon: 8'h06, year: 8'h21, cent: 8'h20};
        tick = 1'b0;
        do_load(t);
        pulse_ticks(55);
        rd_slot(8'h0A, v, vs); chk("R6 count 55 clear", v, 8'h20);
        pulse_ticks(1);
        rd_slot(8'h0A, v, vs); chk("R6 count 56 set", v, 8'hA0);
        pulse_ticks(7);
        rd_slot(8'h0A, v, vs); chk("R6 count 63 set", v, 8'hA0);
        rd_slot(8'h00, v, vs); chk("R7 no step before wrap", v, 8'h30);
        pulse_ticks(1);
        rd_slot(8'h0A, v, vs); chk("R5 status after wrap", v, 8'h20);
        rd_slot(8'h00, v, vs); chk("R7 step at wrap", v, 8'h31);
        repeat (200) @(negedge clk);
        rd_slot(8'h00, v, vs); chk("R7 tick low hold", v, 8'h31);
        // R11: reload mid-second restarts the count
        pulse_ticks(60);
        do_load(t);
        pulse_ticks(60);
        rd_slot(8'h00, v, vs); chk("R11 prescaler restart", v, 8'h30);
        pulse_ticks(4);
        rd_slot(8'h00, v, vs); chk("R11 step after full period", v, 8'h31);
    endtask

    task automatic t_write_time;
        logic [7:0] v, vs;
        rtc_time_t t;
        t = '{sec: 8'h12, mins: 8'h34, hour: 8'h15, wday: 8'h05,
              mday: 8'h09, mon: 8'h10, year: 8'h47, cent: 8'h20};
        tick = 1'b0;
        do_load(t);
        wr_slot(8'h00, 8'h55);
        wr_slot(8'h04, 8'h01);
        wr_slot(8'h32, 8'h77);
        cmp_time("R12 clock kept", t);
        cmp_time("R11 load fields", t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index();
        t_ram();
        t_wide();
        t_preload();
        t_uip();
        t_write_time();
        t_roll("R8 ones carry",
            '{sec: 8'h09, mins: 8'h09, hour: 8'h10, wday: 8'h02, mday: 8'h05, mon: 8'h05, year: 8'h30, cent: 8'h20},
            '{sec: 8'h10, mins: 8'h09, hour: 8'h10, wday: 8'h02, mday: 8'h05, mon: 8'h05, year: 8'h30, cent: 8'h20});
        t_roll("R8 hour carry",
            '{sec: 8'h59, mins: 8'h59, hour: 8'h09, wday: 8'h02, mday: 8'h05, mon: 8'h05, year: 8'h30, cent: 8'h20},
            '{sec: 8'h00, mins: 8'h00, hour: 8'h10, wday: 8'h02, mday: 8'h05, mon: 8'h05, year: 8'h30, cent: 8'h20});
        t_roll("R8 weekday wrap",
            '{sec: 8'h59, mins: 8'h59, hour: 8'h23, wday: 8'h07, mday: 8'h14, mon: 8'h03, year: 8'h30, cent: 8'h20},
            '{sec: 8'h00, mins: 8'h00, hour: 8'h00, wday: 8'h01, mday: 8'h15, mon: 8'h03, year: 8'h30, cent: 8'h20});
        t_roll("R9 april end",
            '{sec: 8'h59, mins: 8'h59, hour: 8'h23, wday: 8'h03, mday: 8'h30, mon: 8'h04, year: 8'h30, cent: 8'h20},
            '{sec: 8'h00, mins: 8'h00, hour: 8'h00, wday: 8'h04, mday: 8'h01, mon: 8'h05, year: 8'h30, cent: 8'h20});
        t_roll("R9 feb 2024 leap",
            '{sec: 8'h59, mins: 8'h59, hour: 8'h23, wday: 8'h04, mday: 8'h28, mon: 8'h02, year: 8'h24, cent: 8'h20},
            '{sec: 8'h00, mins: 8'h00, hour: 8'h00, wday: 8'h05, mday: 8'h29, mon: 8'h02, year: 8'h24, cent: 8'h20});
        t_roll("R9 feb 29 end",
            '{sec: 8'h59, mins: 8'h59, hour: 8'h23, wday: 8'h05, mday: 8'h29, mon: 8'h02, year: 8'h24, cent: 8'h20},
            '{sec: 8'h00, mins: 8'h00, hour: 8'h00, wday: 8'h06, mday: 8'h01, mon: 8'h03, year: 8'h24, cent: 8'h20});
        t_roll("R9 feb 1900 common",
            '{sec: 8'h59, mins: 8'h59, hour: 8'h23, wday: 8'h04, mday: 8'h28, mon: 8'h02, year: 8'h00, cent: 8'h19},
            '{sec: 8'h00, mins: 8'h00, hour: 8'h00, wday: 8'h05, mday: 8'h01, mon: 8'h03, year: 8'h00, cent: 8'h19});
        t_roll("R9 feb 2000 leap",
            '{sec: 8'h59, mins: 8'h59, hour: 8'h23, wday: 8'h02, mday: 8'h28, mon: 8'h02, year: 8'h00, cent: 8'h20},
            '{sec: 8'h00, mins: 8'h00, hour: 8'h00, wday: 8'h03, mday: 8'h29, mon: 8'h02, year: 8'h00, cent: 8'h20});
        t_roll("R9 feb 2023 common",
            '{sec: 8'h59, mins: 8'h59, hour: 8'h23, wday: 8'h03, mday: 8'h28, mon: 8'h02, year: 8'h23, cent: 8'h20},
            '{sec: 8'h00, mins: 8'h00, hour: 8'h00, wday: 8'h04, mday: 8'h01, mon: 8'h03, year: 8'h23, cent: 8'h20});
        t_roll("R10 year end",
            '{sec: 8'h59, mins: 8'h59, hour: 8'h23, wday: 8'h06, mday: 8'h31, mon: 8'h12, year: 8'h09, cent: 8'h20},
            '{sec: 8'h00, mins: 8'h00, hour: 8'h00, wday: 8'h07, mday: 8'h01, mon: 8'h01, year: 8'h10, cent: 8'h20});
        t_roll("R10 century end",
            '{sec: 8'h59, mins: 8'h59, hour: 8'h23, wday: 8'h07, mday: 8'h31, mon: 8'h12, year: 8'h99, cent: 8'h19},
            '{sec: 8'h00, mins: 8'h00, hour: 8'h00, wday: 8'h01, mday: 8'h01, mon: 8'h01, year: 8'h00, cent: 8'h20});
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule